// File: doc/BRIEF.md
# ADC Controller Register Interface

This block is the register front-end of a successive-approximation converter. A simple single-cycle register bus writes and reads a small set of word-aligned registers. Software starts a conversion by writing an input number into the slot-0 channel register. It stops the converter by writing the all-ones channel code. Each finished sample is latched into a result register and sets a completion flag. The completion flag raises the interrupt output when the slot's interrupt enable is set. Reading the result register clears the flag.

The analog converter is replaced by a digital handshake. The block holds `conv_req` high together with the selected channel. Each cycle in which the converter answers with `conv_ack` delivers one raw code. A continuous mode keeps the request high after every completed sample. An overwrite policy decides whether a new sample may replace one that has not been read. A self-clearing calibration request runs a second handshake. It reports pass or fail in a general status register and ends through the same completion flag and interrupt.

Address map, as byte offsets:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | channel control, slot 0 | read/write |
| 0x04 | channel control, slot 1 | read/write |
| 0x08 | status | read-only |
| 0x0C | result, slot 0 | read-only |
| 0x10 | result, slot 1 | read-only |
| 0x14 | configuration | read/write |
| 0x18 | general control | read/write |
| 0x1C | general status | read-only |
| 0x20 to 0x30 | reserved | read as zero |

In both channel control registers, bits [4:0] hold the channel and bit 7 is the interrupt enable. Only slot 0 starts conversions. Slot 1 only holds the value written to it.

Top module: `adc_regif`

## Requirements
- R1: After reset the two channel control registers read 0x1F and every other register reads 0. `irq`, `conv_req` and `cal_req` are low.
- R2: An access to an offset that is not a multiple of 4, or that lies above 0x30, is rejected. A read returns `rsp_err`=1 with data 0, and a write changes nothing. The aligned offsets from 0x20 to 0x30 read 0 with `rsp_err`=0.
- R3: A write to offset 0x00 whose bits [4:0] are not 0x1F starts a conversion. `conv_req` is high from the next cycle and `conv_chan` equals the written channel. While calibration runs, such a write is stored but starts nothing.
- R4: A write of channel code 0x1F to offset 0x00 drops `conv_req` in the next cycle. No further sample is requested.
- R5: A cycle with `conv_req` and `conv_ack` both high completes a sample. Status bit 0 becomes 1, and result register 0x0C returns the code in its low bits. A read of 0x0C clears status bit 0.
- R6: `irq` is high exactly while status bit 0 is set and bit 7 of offset 0x00 is set.
- R7: When configuration bit 16 is 1, a new sample replaces an unread result. When it is 0, a sample that arrives while status bit 0 is set is discarded.
- R8: When general control bit 6 is 1, `conv_req` stays high after each completed sample. When bit 6 is 0, `conv_req` falls after the next completed sample.
- R9: Writing 1 to general control bit 7 aborts any conversion and raises `cal_req` in the next cycle. Bit 7 reads 1 and general status bit 0 (busy) reads 1 until `cal_ack`. At `cal_ack`, bit 7 clears, `cal_req` falls, general status bit 1 takes the value of `cal_fail`, and status bit 0 is set.
- R10: Writes to the status, result and general status registers are ignored.
- R11: Configuration bits [16:0], general control bit 6 and the slot-1 channel register read back as written. Writing slot 1 never starts a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Previous access used an invalid offset |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | CHAN_W | Channel being converted |
| conv_ack | input | 1 | Converter delivers a sample this cycle |
| conv_code | input | CODE_W | Raw sample code |
| cal_req | output | 1 | Calibration request |
| cal_ack | input | 1 | Calibration finished this cycle |
| cal_fail | input | 1 | Calibration result, valid with `cal_ack` |
| irq | output | 1 | Completion interrupt |

## Verification
Register writes take effect at the clock edge that samples them. So `conv_req`, `conv_chan`, `cal_req` and `irq` are checked one cycle after a write or a handshake, at the falling edge that follows that update. Read data comes back one cycle after the read is sampled. A scoreboard queues the expected word and error bit for each read. It compares them when `rsp_valid` shows up, so reads placed right after a result read see the cleared flag. Handshake pulses are driven for exactly one cycle, so each pulse counts as exactly one sample or one calibration end.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

  localparam int SLOTS = 2;

  localparam logic [7:0] OFS_CHCTL  = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h08;
  localparam logic [7:0] OFS_RES    = 8'h0C;
  localparam logic [7:0] OFS_CFG    = 8'h14;
  localparam logic [7:0] OFS_GCTL   = 8'h18;
  localparam logic [7:0] OFS_GSTAT  = 8'h1C;
  localparam logic [7:0] OFS_LAST   = 8'h30;

  localparam int IE_BIT   = 7;
  localparam int CONT_BIT = 6;
  localparam int CAL_BIT  = 7;
  localparam int OVW_BIT  = 16;
  localparam int DONE_BIT = 0;
  localparam int BUSY_BIT = 0;
  localparam int FAIL_BIT = 1;
  localparam int CFG_W    = OVW_BIT + 1;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_CONV = 2'd1,
    ENG_CAL  = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic [SLOTS-1:0] chctl;
    logic             stat;
    logic [SLOTS-1:0] res;
    logic             cfg;
    logic             gctl;
    logic             gstat;
    logic             spare;
  } reg_sel_t;

endpackage

// File: rtl/adc_regif_decode.sv
module adc_regif_decode
  import adc_regif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              err
);

  logic aligned;
  logic in_range;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    in_range = (addr <= ADDR_W'(OFS_LAST));
    err      = !(aligned && in_range);
    sel      = '0;
    if (!err) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (addr == ADDR_W'(OFS_CHCTL) + ADDR_W'(4 * i)) sel.chctl[i] = 1'b1;
        if (addr == ADDR_W'(OFS_RES)   + ADDR_W'(4 * i)) sel.res[i]   = 1'b1;
      end
      if (addr == ADDR_W'(OFS_STAT))  sel.stat  = 1'b1;
      if (addr == ADDR_W'(OFS_CFG))   sel.cfg   = 1'b1;
      if (addr == ADDR_W'(OFS_GCTL))  sel.gctl  = 1'b1;
      if (addr == ADDR_W'(OFS_GSTAT)) sel.gstat = 1'b1;
      if (sel == '0) sel.spare = 1'b1;
    end
  end

endmodule

// File: rtl/adc_regif_engine.sv
module adc_regif_engine
  import adc_regif_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              cal_go,
  input  logic              cont,
  input  logic              conv_ack,
  input  logic              cal_ack,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              cal_req,
  output logic              sample_valid,
  output logic              cal_done
);

  eng_state_t        state_q, state_d;
  logic [CHAN_W-1:0] chan_q, chan_d;

  assign conv_req     = (state_q == ENG_CONV);
  assign cal_req      = (state_q == ENG_CAL);
  assign conv_chan    = chan_q;
  assign sample_valid = conv_req && conv_ack;
  assign cal_done     = cal_req && cal_ack;

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (cal_go) begin
          state_d = ENG_CAL;
        end else if (start) begin
          state_d = ENG_CONV;
          chan_d  = chan_in;
        end
      end
      ENG_CONV: begin
        if (cal_go) begin
          state_d = ENG_CAL;
        end else if (stop) begin
          state_d = ENG_IDLE;
        end else if (start) begin
          chan_d  = chan_in;
        end else if (conv_ack && !cont) begin
          state_d = ENG_IDLE;
        end
      end
      ENG_CAL: begin
        if (cal_ack) state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      chan_q  <= '1;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
    end
  end

endmodule

// File: rtl/adc_regif_result.sv
module adc_regif_result #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] sample_code,
  input  logic              cal_done,
  input  logic              rd_clear,
  input  logic              ovw_en,
  output logic              done,
  output logic [CODE_W-1:0] code
);

  logic              done_d;
  logic [CODE_W-1:0] code_d;
  logic              latch_en;

  always_comb begin
    latch_en = sample_valid && (!done || ovw_en || rd_clear);
    code_d   = latch_en ? sample_code : code;
    if (sample_valid || cal_done) done_d = 1'b1;
    else if (rd_clear)            done_d = 1'b0;
    else                          done_d = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      code <= '0;
    end else begin
      done <= done_d;
      if (latch_en) code <= code_d;
    end
  end

endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CHAN_W = 5,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_ack,
  input  logic [CODE_W-1:0] conv_code,
  output logic              cal_req,
  input  logic              cal_ack,
  input  logic              cal_fail,
  output logic              irq
);

  localparam logic [CHAN_W-1:0] STOP_CODE = '1;

  reg_sel_t          sel;
  logic              addr_err;
  logic              wr_en;
  logic              rd_en;
  logic              start_w;
  logic              stop_w;
  logic              cal_go;
  logic              rd_clear_w;
  logic              sample_valid;
  logic              cal_done;
  logic              done_w;
  logic [CODE_W-1:0] res_code_w;

  logic [CHAN_W-1:0] chan_q [SLOTS];
  logic              ie_q   [SLOTS];
  logic [CFG_W-1:0]  cfg_q,  cfg_d;
  logic              cont_q, cont_d;
  logic              cal_q,  cal_d;
  logic              fail_q, fail_d;
  logic [DATA_W-1:0] rdata_d;

  adc_regif_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .sel  (sel),
    .err  (addr_err)
  );

  assign wr_en      = req_valid && req_write && !addr_err;
  assign rd_en      = req_valid && !req_write;
  assign start_w    = wr_en && sel.chctl[0] && (req_wdata[CHAN_W-1:0] != STOP_CODE);
  assign stop_w     = wr_en && sel.chctl[0] && (req_wdata[CHAN_W-1:0] == STOP_CODE);
  assign cal_go     = wr_en && sel.gctl && req_wdata[CAL_BIT];
  assign rd_clear_w = rd_en && !addr_err && sel.res[0];

  adc_regif_engine #(.CHAN_W(CHAN_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start_w),
    .stop         (stop_w),
    .chan_in      (req_wdata[CHAN_W-1:0]),
    .cal_go       (cal_go),
    .cont         (cont_q),
    .conv_ack     (conv_ack),
    .cal_ack      (cal_ack),
    .conv_req     (conv_req),
    .conv_chan    (conv_chan),
    .cal_req      (cal_req),
    .sample_valid (sample_valid),
    .cal_done     (cal_done)
  );

  adc_regif_result #(.CODE_W(CODE_W)) u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_code  (conv_code),
    .cal_done     (cal_done),
    .rd_clear     (rd_clear_w),
    .ovw_en       (cfg_q[OVW_BIT]),
    .done         (done_w),
    .code         (res_code_w)
  );

  // channel control slots
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              wr_slot;
    logic [CHAN_W-1:0] chan_d;
    logic              ie_d;

    always_comb begin
      wr_slot = wr_en && sel.chctl[s];
      chan_d  = wr_slot ? req_wdata[CHAN_W-1:0] : chan_q[s];
      ie_d    = wr_slot ? req_wdata[IE_BIT]     : ie_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_q[s] <= STOP_CODE;
        ie_q[s]   <= 1'b0;
      end else if (wr_slot) begin
        chan_q[s] <= chan_d;
        ie_q[s]   <= ie_d;
      end
    end
  end

  // configuration and general control next state
  always_comb begin
    cfg_d  = (wr_en && sel.cfg)  ? req_wdata[CFG_W-1:0] : cfg_q;
    cont_d = (wr_en && sel.gctl) ? req_wdata[CONT_BIT]  : cont_q;
    if (cal_done)    cal_d = 1'b0;
    else if (cal_go) cal_d = 1'b1;
    else             cal_d = cal_q;
    fail_d = cal_done ? cal_fail : fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cont_q <= 1'b0;
      cal_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cont_q <= cont_d;
      cal_q  <= cal_d;
      fail_q <= fail_d;
    end
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sel.chctl[i]) begin
        rdata_d[CHAN_W-1:0] = chan_q[i];
        rdata_d[IE_BIT]     = ie_q[i];
      end
    end
    if (sel.stat)   rdata_d[DONE_BIT]     = done_w;
    if (sel.res[0]) rdata_d[CODE_W-1:0]   = res_code_w;
    if (sel.cfg)    rdata_d[CFG_W-1:0]    = cfg_q;
    if (sel.gctl) begin
      rdata_d[CONT_BIT] = cont_q;
      rdata_d[CAL_BIT]  = cal_q;
    end
    if (sel.gstat) begin
      rdata_d[BUSY_BIT] = cal_req;
      rdata_d[FAIL_BIT] = fail_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      rsp_err   <= req_valid && addr_err;
      if (rd_en) rsp_rdata <= addr_err ? '0 : rdata_d;
    end
  end

  assign irq = ie_q[0] && done_w;

endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int DATA_W = 32,
  parameter int CHAN_W = 5,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_req,
  input logic              conv_ack,
  input logic [CHAN_W-1:0] conv_chan,
  input logic              cal_req,
  input logic              cal_ack,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              start,
  input logic              stop,
  input logic [CHAN_W-1:0] wchan,
  input logic              done,
  input logic [CODE_W-1:0] res_code,
  input logic              ovw,
  input logic              rd_clear
);

  assert_one_engine_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_req && cal_req));

  assert_cal_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && cal_ack) |=> !cal_req);

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cal_req) |=> (conv_req && conv_chan == $past(wchan)));

  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !conv_req);

  assert_done_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_ack) |=> done);

  assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_ack && done && !ovw && !rd_clear) |=> $stable(res_code));

  assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

endmodule

bind adc_regif adc_regif_chk #(
  .DATA_W (DATA_W),
  .CHAN_W (CHAN_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_req  (conv_req),
  .conv_ack  (conv_ack),
  .conv_chan (conv_chan),
  .cal_req   (cal_req),
  .cal_ack   (cal_ack),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .start     (start_w),
  .stop      (stop_w),
  .wchan     (req_wdata[CHAN_W-1:0]),
  .done      (done_w),
  .res_code  (res_code_w),
  .ovw       (cfg_q[16]),
  .rd_clear  (rd_clear_w)
);

// File: tb/adc_regif_test.sv
`timescale 1ns/1ps
module adc_regif_test;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CHAN_W = 5;
  localparam int CODE_W = 12;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_err;
  logic              conv_req;
  logic [CHAN_W-1:0] conv_chan;
  logic              conv_ack;
  logic [CODE_W-1:0] conv_code;
  logic              cal_req;
  logic              cal_ack;
  logic              cal_fail;
  logic              irq;

  int checks;
  int failures;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              err;
    string             tag;
  } exp_t;

  exp_t exp_q[$];

  adc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .CODE_W(CODE_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_code(conv_code),
    .cal_req(cal_req), .cal_ack(cal_ack), .cal_fail(cal_fail), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic e, input string tag);
    exp_t x;
    x.data = d; x.err = e; x.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(x);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic give_sample(input logic [CODE_W-1:0] code);
    @(negedge clk);
    conv_ack = 1'b1; conv_code = code;
    @(negedge clk);
    conv_ack = 1'b0;
  endtask

  task automatic give_cal(input logic f);
    @(negedge clk);
    cal_ack = 1'b1; cal_fail = f;
    @(negedge clk);
    cal_ack = 1'b0; cal_fail = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected response actual=0x%0h expected=none", rsp_rdata);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        chk(x.tag, rsp_rdata, x.data);
        chk({x.tag, " err"}, {31'd0, rsp_err}, {31'd0, x.err});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    conv_ack = 0; conv_code = '0; cal_ack = 0; cal_fail = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 conv_req", {31'd0, conv_req}, 0);
    chk("R1 cal_req", {31'd0, cal_req}, 0);
    bus_read(8'h00, 32'h1F, 0, "R1 chctl0");
    bus_read(8'h04, 32'h1F, 0, "R1 chctl1");
    bus_read(8'h08, 0, 0, "R1 stat");
    bus_read(8'h0C, 0, 0, "R1 res0");
    bus_read(8'h14, 0, 0, "R1 cfg");
    bus_read(8'h18, 0, 0, "R1 gctl");
    bus_read(8'h1C, 0, 0, "R1 gstat");

    // R3 start, R5 result, R6 irq
    bus_write(8'h00, 32'h85);
    chk("R3 conv_req", {31'd0, conv_req}, 1);
    chk("R3 conv_chan", {27'd0, conv_chan}, 5);
    give_sample(12'hABC);
    chk("R6 irq set", {31'd0, irq}, 1);
    chk("R8 one-shot drop", {31'd0, conv_req}, 0);
    bus_read(8'h08, 1, 0, "R5 stat set");
    bus_read(8'h0C, 32'hABC, 0, "R5 res0");
    bus_read(8'h08, 0, 0, "R5 stat cleared");
    chk("R6 irq cleared", {31'd0, irq}, 0);

    // R7 overwrite policy
    bus_write(8'h00, 32'h81);
    give_sample(12'h111);
    bus_write(8'h00, 32'h81);
    give_sample(12'h222);
    bus_read(8'h0C, 32'h111, 0, "R7 discard");
    bus_write(8'h14, 32'h0001_0000);
    bus_read(8'h14, 32'h0001_0000, 0, "R11 cfg");
    bus_write(8'h00, 32'h81);
    give_sample(12'h444);
    bus_write(8'h00, 32'h81);
    give_sample(12'h555);
    bus_read(8'h0C, 32'h555, 0, "R7 overwrite");

    // R8 continuous
    bus_write(8'h18, 32'h40);
    bus_read(8'h18, 32'h40, 0, "R11 gctl");
    bus_write(8'h00, 32'h83);
    chk("R3 chan 3", {27'd0, conv_chan}, 3);
    give_sample(12'h010);
    chk("R8 hold 1", {31'd0, conv_req}, 1);
    give_sample(12'h020);
    chk("R8 hold 2", {31'd0, conv_req}, 1);
    bus_write(8'h18, 32'h00);
    give_sample(12'h030);
    chk("R8 drop", {31'd0, conv_req}, 0);
    bus_read(8'h0C, 32'h030, 0, "R8 last code");

    // R4 stop
    bus_write(8'h00, 32'h02);
    chk("R3 chan 2", {31'd0, conv_req}, 1);
    bus_write(8'h00, 32'h1F);
    chk("R4 stopped", {31'd0, conv_req}, 0);
    bus_read(8'h00, 32'h1F, 0, "R4 chctl0");

    // R6 enable gating
    bus_write(8'h00, 32'h04);
    give_sample(12'h0AA);
    chk("R6 ie off", {31'd0, irq}, 0);
    bus_write(8'h00, 32'h9F);
    chk("R6 ie on", {31'd0, irq}, 1);

    // R10 read-only registers
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_read(8'h08, 1, 0, "R10 stat");
    bus_read(8'h1C, 0, 0, "R10 gstat");
    bus_read(8'h0C, 32'h0AA, 0, "R10 res0");

    // R9 calibration
    bus_write(8'h18, 32'h80);
    chk("R9 cal_req", {31'd0, cal_req}, 1);
    chk("R9 no conv", {31'd0, conv_req}, 0);
    bus_read(8'h18, 32'h80, 0, "R9 gctl busy");
    bus_read(8'h1C, 32'h1, 0, "R9 gstat busy");
    give_cal(1'b1);
    chk("R9 cal_req drop", {31'd0, cal_req}, 0);
    chk("R9 irq", {31'd0, irq}, 1);
    bus_read(8'h1C, 32'h2, 0, "R9 fail flag");
    bus_read(8'h18, 0, 0, "R9 self clear");
    bus_read(8'h08, 1, 0, "R9 done");
    bus_read(8'h0C, 32'h0AA, 0, "R9 result kept");
    bus_write(8'h18, 32'h80);
    give_cal(1'b0);
    bus_read(8'h1C, 0, 0, "R9 pass");

    // R2 address checks, R11 slot 1
    bus_read(8'h02, 0, 1, "R2 unaligned");
    bus_read(8'h34, 0, 1, "R2 beyond");
    bus_read(8'h20, 0, 0, "R2 reserved");
    bus_read(8'h10, 0, 0, "R2 res1");
    bus_write(8'h01, 32'h85);
    chk("R2 bad write", {31'd0, conv_req}, 0);
    bus_read(8'h00, 32'h9F, 0, "R2 chctl0 kept");
    bus_write(8'h04, 32'h86);
    chk("R11 slot1 no start", {31'd0, conv_req}, 0);
    bus_read(8'h04, 32'h86, 0, "R11 chctl1");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule